// File: doc/BRIEF.md
# Synchronous ROM Command Decoder

This block is the device-side front end of a synchronous mask ROM. On every rising clock edge it samples a select strobe, a row strobe, a column strobe, a mode strobe, a clock enable and a 13-bit multiplexed address. From these it decodes a row activate, a read, a burst stop or a mode write. Other inputs produce a no-op, a deselect, or a flagged illegal command. When the clock enable is sampled low, the command sampled on that same edge still counts, and the internal clock is frozen from the following edge on.

The block keeps a 7-bit mode word and presents its fields in decoded form: RAS latency, CAS latency, burst length and burst type. It latches the row address on an activate and the column address on a read. Each accepted command is reported to the read path as a one-cycle pulse. After a mode write the decoder refuses commands for a fixed number of edges. It also refuses a mode write while a row is open or a burst is still in flight. The cell array and the output drivers belong to other blocks.

Top module: `srom_cmd_decoder`

## Requirements
- R1: After reset the mode word is 7'h11: RAS latency 1 (rl_two=0), CAS latency 3, burst of 4, sequential. All pulses are low and frozen is low.
- R2: A mode write is sel_n, row_stb_n, col_stb_n and mode_stb_n all low on one edge. When it is accepted, addr[6:0] is loaded and mrs_pls rises. The fields are: addr[1:0] burst length (01 is 4, 10 is 8); addr[2] type (1 is interleaved); addr[5:3] CAS latency code (010..101 mean 3..6); addr[6] RAS latency (0 is 1, 1 is 2).
- R3: A mode write carrying a reserved burst code (00, 11) or a reserved latency code (anything outside 010..101) leaves the mode word unchanged and pulses err_pls.
- R4: For the 3 edges after an accepted mode write, every command is ignored. The 4th edge accepts commands again.
- R5: Row activate is sel_n=0, row_stb_n=0, col_stb_n=1, mode_stb_n=1. It pulses act_pls and latches addr[12:0] into row_addr. With repeated activates, the last row address is kept.
- R6: Read is sel_n=0, row_stb_n=1, col_stb_n=0, mode_stb_n=1. It pulses rd_pls and latches addr[8:0] into col_addr.
- R7: With sel_n=0, col_stb_n=1 and mode_stb_n=0, the command is a burst stop whatever row_stb_n is. It pulses stop_pls, closes the open row and ends any burst in flight.
- R8: A no-op (row, column and mode strobes all high) and a deselect (sel_n=1) produce no pulse and change no output.
- R9: A mode write is illegal while a row is open or while a read is in flight. A read is in flight for the CAS latency plus burst length edges after it. An illegal mode write pulses illegal_pls and leaves the mode word unchanged.
- R10: Two more strobe patterns pulse illegal_pls: row strobe high with column and mode strobes low, and row and column strobes low with mode strobe high.
- R11: When clk_en is sampled low, the command on that edge is still decoded, and later edges are ignored while frozen is high. After clk_en is sampled high again, that edge and the next are ignored, and the edge after that accepts commands.
- R12: At most one of the six pulse outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable, sampled each edge |
| sel_n | input | 1 | Device select, active low |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| mode_stb_n | input | 1 | Mode strobe, active low |
| addr | input | 13 | Multiplexed row, column and mode-code address |
| rl_two | output | 1 | RAS latency is 2 (else 1) |
| cl_lat | output | 3 | CAS latency, 3 to 6 |
| bl_eight | output | 1 | Burst of 8 (else 4) |
| intlv | output | 1 | Interleaved burst order |
| row_addr | output | 13 | Latched row address |
| col_addr | output | 9 | Latched column address |
| act_pls | output | 1 | Row activate accepted |
| rd_pls | output | 1 | Read accepted |
| stop_pls | output | 1 | Burst stop accepted |
| mrs_pls | output | 1 | Mode write accepted |
| illegal_pls | output | 1 | Illegal command seen |
| err_pls | output | 1 | Reserved mode code rejected |
| frozen | output | 1 | Internal clock masked by clk_en |

## Verification
Two checks can land on the same edge: the busy check on a mode write and the reserved-code check. The bench provokes this by issuing mode writes with reserved codes while a row is open or a burst is in flight. The expected result is illegal_pls alone, with no err_pls and no change to the mode word. A second overlap is a clk_en drop on the same edge as a command. The bench expects that command to be accepted, and it expects the lockout countdown and the burst count to pause while frozen.

// File: rtl/srom_cmd_decoder.sv
module srom_cmd_decoder #(
  parameter int          ADDR_W   = 13,
  parameter int          COL_W    = 9,
  parameter int          LOCK_CYC = 3,
  parameter int          CNT_W    = 4,
  parameter logic [6:0]  MODE_RST = 7'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sel_n,
  input  logic              row_stb_n,
  input  logic              col_stb_n,
  input  logic              mode_stb_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rl_two,
  output logic [2:0]        cl_lat,
  output logic              bl_eight,
  output logic              intlv,
  output logic [ADDR_W-1:0] row_addr,
  output logic [COL_W-1:0]  col_addr,
  output logic              act_pls,
  output logic              rd_pls,
  output logic              stop_pls,
  output logic              mrs_pls,
  output logic              illegal_pls,
  output logic              err_pls,
  output logic              frozen
);
  localparam int LOCK_W = $clog2(LOCK_CYC + 1);

  logic              cke_q, wake_q, row_open;
  logic [LOCK_W-1:0] lock_q;
  logic [CNT_W-1:0]  rd_cnt;
  logic [6:0]        mode_q;

  wire step = cke_q & ~wake_q;
  wire sel  = step & (lock_q == '0) & ~sel_n;

  wire is_mrs  = sel & ~row_stb_n & ~col_stb_n & ~mode_stb_n;
  wire is_act  = sel & ~row_stb_n &  col_stb_n &  mode_stb_n;
  wire is_rd   = sel &  row_stb_n & ~col_stb_n &  mode_stb_n;
  wire is_stop = sel &  col_stb_n & ~mode_stb_n;
  wire is_bad  = sel & ((row_stb_n & ~col_stb_n & ~mode_stb_n) |
                        (~row_stb_n & ~col_stb_n & mode_stb_n));

  wire busy    = row_open | (rd_cnt != '0);
  wire bl_ok   = (addr[1:0] == 2'b01) | (addr[1:0] == 2'b10);
  wire cl_ok   = (addr[5:3] >= 3'd2) & (addr[5:3] <= 3'd5);
  wire mrs_go  = is_mrs & ~busy & bl_ok & cl_ok;
  wire mrs_rej = is_mrs & ~busy & ~(bl_ok & cl_ok);
  wire illegal = is_bad | (is_mrs & busy);

  wire [CNT_W-1:0] rd_len = CNT_W'(mode_q[5:3]) + CNT_W'(1) +
                            ((mode_q[1:0] == 2'b10) ? CNT_W'(8) : CNT_W'(4));

  assign rl_two   = mode_q[6];
  assign cl_lat   = mode_q[5:3] + 3'd1;
  assign intlv    = mode_q[2];
  assign bl_eight = (mode_q[1:0] == 2'b10);
  assign frozen   = ~cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q       <= 1'b1;
      wake_q      <= 1'b0;
      row_open    <= 1'b0;
      lock_q      <= '0;
      rd_cnt      <= '0;
      mode_q      <= MODE_RST;
      row_addr    <= '0;
      col_addr    <= '0;
      act_pls     <= 1'b0;
      rd_pls      <= 1'b0;
      stop_pls    <= 1'b0;
      mrs_pls     <= 1'b0;
      illegal_pls <= 1'b0;
      err_pls     <= 1'b0;
    end else begin
      cke_q  <= clk_en;
      wake_q <= ~cke_q;
      if (mrs_go)
        lock_q <= LOCK_W'(LOCK_CYC);
      else if (step && lock_q != '0)
        lock_q <= lock_q - 1'b1;
      if (is_stop)
        rd_cnt <= '0;
      else if (is_rd)
        rd_cnt <= rd_len;
      else if (step && rd_cnt != '0)
        rd_cnt <= rd_cnt - 1'b1;
      if (is_act)
        row_open <= 1'b1;
      else if (is_stop)
        row_open <= 1'b0;
      if (mrs_go) mode_q   <= addr[6:0];
      if (is_act) row_addr <= addr;
      if (is_rd)  col_addr <= addr[COL_W-1:0];
      act_pls     <= is_act;
      rd_pls      <= is_rd;
      stop_pls    <= is_stop;
      mrs_pls     <= mrs_go;
      illegal_pls <= illegal;
      err_pls     <= mrs_rej;
    end
  end

  wire any_pls = act_pls | rd_pls | stop_pls | mrs_pls | illegal_pls | err_pls;

  // R12
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_pls, rd_pls, stop_pls, mrs_pls, illegal_pls, err_pls}));

  // R4
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_pls |=> !any_pls ##1 !any_pls ##1 !any_pls);

  // R11
  frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> !any_pls);

  // R3, R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_pls | err_pls) |-> $stable({rl_two, cl_lat, bl_eight, intlv}));

  // R5
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_pls |-> $stable(row_addr));

  // R6
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pls |-> $stable(col_addr));
endmodule

// File: tb/srom_cmd_decoder_tb.sv
module srom_cmd_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en = 1'b1, sel_n = 1'b1, row_stb_n = 1'b1, col_stb_n = 1'b1, mode_stb_n = 1'b1;
  logic [12:0] addr = '0;
  logic rl_two, bl_eight, intlv, act_pls, rd_pls, stop_pls, mrs_pls, illegal_pls, err_pls, frozen;
  logic [2:0] cl_lat;
  logic [12:0] row_addr;
  logic [8:0] col_addr;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  srom_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_n(sel_n), .row_stb_n(row_stb_n),
    .col_stb_n(col_stb_n), .mode_stb_n(mode_stb_n), .addr(addr),
    .rl_two(rl_two), .cl_lat(cl_lat), .bl_eight(bl_eight), .intlv(intlv),
    .row_addr(row_addr), .col_addr(col_addr), .act_pls(act_pls), .rd_pls(rd_pls),
    .stop_pls(stop_pls), .mrs_pls(mrs_pls), .illegal_pls(illegal_pls),
    .err_pls(err_pls), .frozen(frozen));

  bit m_cke = 1, m_wake = 0, m_row = 0;
  int m_lock = 0, m_rd = 0;
  logic [6:0] m_mode = 7'h11;
  logic [12:0] m_rowa = '0;
  logic [8:0] m_cola = '0;
  bit e_act, e_rd, e_stop, e_mrs, e_ill, e_err;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit code_ok(input logic [6:0] c);
    return (c[1:0] == 2'b01 || c[1:0] == 2'b10) && c[5:3] >= 3'd2 && c[5:3] <= 3'd5;
  endfunction

  task automatic model_edge();
    bit live, go, s, r, cs, ms, busy;
    live = m_cke && !m_wake;
    go = live && m_lock == 0 && !sel_n;
    r = row_stb_n; cs = col_stb_n; ms = mode_stb_n;
    busy = m_row || m_rd > 0;
    e_act = go && !r && cs && ms;
    e_rd = go && r && !cs && ms;
    e_stop = go && cs && !ms;
    s = go && !r && !cs && !ms;
    e_ill = (go && ((r && !cs && !ms) || (!r && !cs && ms))) || (s && busy);
    e_mrs = s && !busy && code_ok(addr[6:0]);
    e_err = s && !busy && !code_ok(addr[6:0]);
    if (e_mrs) m_lock = 3; else if (live && m_lock > 0) m_lock--;
    if (e_stop) m_rd = 0;
    else if (e_rd) m_rd = int'(m_mode[5:3]) + 1 + (m_mode[1:0] == 2'b10 ? 8 : 4);
    else if (live && m_rd > 0) m_rd--;
    if (e_act) m_row = 1; else if (e_stop) m_row = 0;
    if (e_mrs) m_mode = addr[6:0];
    if (e_act) m_rowa = addr;
    if (e_rd) m_cola = addr[8:0];
    m_wake = !m_cke;
    m_cke = clk_en;
  endtask

  task automatic compare();
    chk("R2/R3 rl_two", rl_two, m_mode[6]);
    chk("R2/R3 cl_lat", cl_lat, m_mode[5:3] + 3'd1);
    chk("R2/R3 bl_eight", bl_eight, m_mode[1:0] == 2'b10);
    chk("R2/R3 intlv", intlv, m_mode[2]);
    chk("R5 row_addr", row_addr, m_rowa);
    chk("R6 col_addr", col_addr, m_cola);
    chk("R5 act_pls", act_pls, e_act);
    chk("R6 rd_pls", rd_pls, e_rd);
    chk("R7 stop_pls", stop_pls, e_stop);
    chk("R2/R4 mrs_pls", mrs_pls, e_mrs);
    chk("R9/R10 illegal_pls", illegal_pls, e_ill);
    chk("R3 err_pls", err_pls, e_err);
    chk("R11 frozen", frozen, !m_cke);
  endtask

  task automatic cyc(input bit ce, input bit s, input bit r, input bit c, input bit m, input logic [12:0] a);
    @(negedge clk);
    clk_en = ce; sel_n = s; row_stb_n = r; col_stb_n = c; mode_stb_n = m; addr = a;
    @(posedge clk);
    model_edge();
    #1.5;
    compare();
  endtask

  task automatic nop(); cyc(1, 0, 1, 1, 1, $urandom); endtask
  task automatic act(input logic [12:0] a); cyc(1, 0, 0, 1, 1, a); endtask
  task automatic rd(input logic [12:0] a); cyc(1, 0, 1, 0, 1, a); endtask
  task automatic stp(); cyc(1, 0, 1, 1, 0, 0); endtask
  task automatic mrs(input logic [6:0] c); cyc(1, 0, 0, 0, 0, {6'd0, c}); endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rl_two", rl_two, 0);
    chk("R1 cl_lat", cl_lat, 3);
    chk("R1 bl_eight", bl_eight, 0);
    chk("R1 intlv", intlv, 0);
    chk("R1 pulses", {act_pls, rd_pls, stop_pls, mrs_pls, illegal_pls, err_pls, frozen}, 0);

    // R2 legal write: RL2, CL5, interleaved, BL8
    mrs(7'b1_100_1_10);
    chk("R2 cl_lat", cl_lat, 5);
    chk("R2 rl_two/bl_eight/intlv", {rl_two, bl_eight, intlv}, 3'b111);
    // R4 three ignored edges, then accepted
    act(13'h0AA); act(13'h0BB); act(13'h0CC);
    chk("R4 lockout row_addr", row_addr, 0);
    act(13'h1234);
    chk("R4 accept after lockout", act_pls, 1);
    // R5 last activate wins
    act(13'h0F0F);
    chk("R5 last row", row_addr, 13'h0F0F);
    // R9 mode write with row open; reserved code too: illegal only
    mrs(7'b0_111_0_00);
    chk("R9 illegal with open row", {illegal_pls, err_pls}, 2'b10);
    // R6 read
    rd(13'h1FF);
    chk("R6 col", col_addr, 9'h1FF);
    // R7 stop with row strobe low
    cyc(1, 0, 0, 1, 0, 0);
    chk("R7 stop ras low", stop_pls, 1);
    // R3 reserved code while idle
    mrs(7'b0_001_0_01);
    chk("R3 err", err_pls, 1);
    chk("R3 mode kept", cl_lat, 5);
    // R9 read in flight: CL5 + BL8 = 13 edges busy
    rd(13'h005);
    for (int i = 0; i < 12; i++) nop();
    mrs(7'h11);
    chk("R9 in flight", illegal_pls, 1);
    mrs(7'h11);
    chk("R9 window over", mrs_pls, 1);
    repeat (3) nop();
    // R10 other illegal patterns
    cyc(1, 0, 1, 0, 0, 0);
    chk("R10 pattern a", illegal_pls, 1);
    cyc(1, 0, 0, 0, 1, 0);
    chk("R10 pattern b", illegal_pls, 1);
    // R8 deselect ignores strobes
    cyc(1, 1, 0, 1, 1, 13'h777);
    chk("R8 deselect", {act_pls, row_addr != 13'h777}, 2'b01);
    // R11 command on falling clk_en edge taken, then frozen
    cyc(0, 0, 0, 1, 1, 13'h0111);
    chk("R11 drop edge accepted", act_pls, 1);
    act(13'h0222);
    chk("R11 frozen ignores", row_addr, 13'h0111);
    act(13'h0333);
    chk("R11 wake ignores", row_addr, 13'h0111);
    act(13'h0444);
    chk("R11 accepted after wake", row_addr, 13'h0444);
    stp();

    for (int n = 0; n < 6000; n++) begin
      int k = $urandom_range(0, 11);
      bit ce = ($urandom_range(0, 15) != 0);
      logic [12:0] a = 13'($urandom);
      case (k)
        0: cyc(ce, 0, 1, 1, 1, a);
        1: cyc(ce, 1, 1'($urandom), 1'($urandom), 1'($urandom), a);
        2, 3: cyc(ce, 0, 0, 1, 1, a);
        4, 5: cyc(ce, 0, 1, 0, 1, a);
        6, 7: cyc(ce, 0, 1'($urandom), 1, 0, a);
        8: cyc(ce, 0, 0, 0, 0, {6'd0, 7'($urandom)});
        9: cyc(ce, 0, 0, 0, 0, {6'd0, 1'($urandom), 3'($urandom_range(2, 5)),
                                1'($urandom), 2'($urandom_range(1, 2))});
        10: cyc(ce, 0, 1'($urandom), 0, ~row_stb_n, a);
        default: cyc(ce, 0, 1, 1, 1, a);
      endcase
      // R12 at most one pulse
      chk("R12 onehot", $countones({act_pls, rd_pls, stop_pls, mrs_pls, illegal_pls, err_pls}) <= 1, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule